// File: doc/BRIEF.md
# Mode-Configurable SPI Slave Shifter

This block is the receive/transmit engine of an SPI slave. It runs entirely in a fast system clock domain. The serial clock, data-in and active-low select pins are brought in as plain inputs and passed through synchronizers, and the block recovers serial clock edges from them. Two configuration inputs choose the idle level of the serial clock (polarity) and which of the two clock edges samples data (phase). The configuration is frozen for as long as the slave is selected.

The system side loads a parallel byte while the slave is deselected and collects each received byte on `rx_byte`, qualified by a `rx_done` strobe that lasts one cycle. The shift register is circular: every sampled bit enters at one end while the other end drives the serial output. After a full byte, the serial output therefore shows the first bit of the byte just received. Several bytes may follow one another under a single select. A select released early abandons the partial byte.

Top module: `spi_slave_shifter`

## Requirements
- R1: While and after reset, `miso_oe` is 0, `rx_done` is 0 and `rx_byte` is 0x00.
- R2: A `tx_load` pulse while the synchronized select is high copies `tx_byte` into the shift register, and `miso_out` then shows `tx_byte` bit 7 (bit 7 is sent first).
- R3: A `tx_load` pulse while the slave is selected is ignored, and the byte being sent is unaffected.
- R4: `miso_oe` is 1 exactly while the synchronized `ss_n_in` is low (two system clocks of latency) and 0 otherwise.
- R5: With phase 0, `miso_out` shows bit 7 as soon as the slave is selected. `mosi_in` is sampled on the leading serial clock edge, and `miso_out` advances to the next bit on the trailing edge.
- R6: With phase 1, `miso_out` advances on each leading edge after the first, and `mosi_in` is sampled on the trailing edge.
- R7: With polarity 0 the serial clock idles low and its leading edge is rising. With polarity 1 it idles high and its leading edge is falling.
- R8: Data is sent and received bit 7 first. On the eighth sampled bit, `rx_byte` takes the received byte and `rx_done` is high for exactly one system clock.
- R9: After the eighth bit, `miso_out` shows bit 7 of the byte just received.
- R10: Changes on `cfg_cpol`/`cfg_cpha` while the slave is selected have no effect until the select is released.
- R11: Releasing the select before eight bits are sampled clears the bit count and raises no `rx_done`. The next selection starts a fresh byte.
- R12: While the select stays low, the bit counter wraps after each byte, so consecutive bytes each produce their own `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling edge select (0 leading, 1 trailing) |
| tx_load | input | 1 | Load strobe for `tx_byte` |
| tx_byte | input | 8 | Byte to send next |
| sck_in | input | 1 | Serial clock from master (asynchronous) |
| mosi_in | input | 1 | Serial data from master (asynchronous) |
| ss_n_in | input | 1 | Active-low slave select (asynchronous) |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the serial data pad |
| rx_byte | output | 8 | Last complete received byte |
| rx_done | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The checker watches several rules on every cycle:
- the single-cycle width of `rx_done`, and that it only follows a sampling edge while selected;
- that `rx_byte` holds between strobes;
- that the latched mode never moves while selected;
- that `miso_out` holds while selected unless a shift or sample edge occurred, which covers the ignored load.

Only the bench scenarios show the rest:
- the bit-exact serial values in all four modes;
- the circular echo of the received MSB;
- aborted and back-to-back bytes;
- tolerance of mid-transfer configuration changes.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   typedef struct packed {
      logic cpol;
      logic cpha;
   } spi_mode_t;

   localparam int unsigned SYNC_MIN = 2;

   function automatic logic lead_edge(input logic cpol, input logic rise, input logic fall);
      return cpol ? fall : rise;
   endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
   import spi_slv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sck_s,
   input  logic      active,
   input  spi_mode_t mode,
   output logic      smp_stb,
   output logic      shf_stb
);

   logic sck_d;
   logic rise, fall, lead, trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise  = sck_s & ~sck_d;
   assign fall  = ~sck_s & sck_d;
   assign lead  = lead_edge(mode.cpol, rise, fall);
   assign trail = lead_edge(mode.cpol, fall, rise);

   assign smp_stb = active & (mode.cpha ? trail : lead);
   assign shf_stb = active & (mode.cpha ? lead : trail);

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spi_mode_t         cfg_mode,
   input  logic              ss_s,
   input  logic              mosi_s,
   input  logic              smp_stb,
   input  logic              shf_stb,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   output spi_mode_t         mode_q,
   output logic              miso_bit,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done
);

   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sr;
   logic [DATA_W-1:0] sh_now, sh_pend;
   logic [CNT_W-1:0]  cnt;
   logic              pend;
   logic              smp_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_now   = {sr[DATA_W-2:0], mosi_s};
         assign sh_pend  = {sr[DATA_W-2:0], smp_bit};
         assign miso_bit = sr[DATA_W-1];
      end else begin : g_lsb
         assign sh_now   = {mosi_s, sr[DATA_W-1:1]};
         assign sh_pend  = {smp_bit, sr[DATA_W-1:1]};
         assign miso_bit = sr[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         cnt     <= '0;
         pend    <= 1'b0;
         smp_bit <= 1'b0;
         sr      <= '0;
         rx_byte <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         if (ss_s) begin
            // deselected: accept configuration and loads, drop any partial byte
            mode_q <= cfg_mode;
            cnt    <= '0;
            pend   <= 1'b0;
            if (tx_load) sr <= tx_byte;
         end else if (smp_stb) begin
            smp_bit <= mosi_s;
            if (cnt == LAST_IDX) begin
               cnt     <= '0;
               rx_done <= 1'b1;
               rx_byte <= sh_now;
               if (mode_q.cpha) begin
                  sr   <= sh_now;
                  pend <= 1'b0;
               end else begin
                  pend <= 1'b1;
               end
            end else begin
               cnt  <= cnt + 1'b1;
               pend <= 1'b1;
            end
         end else if (shf_stb && pend) begin
            sr   <= sh_pend;
            pend <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              sck_in,
   input  logic              mosi_in,
   input  logic              ss_n_in,
   output logic              miso_out,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_slave_shifter: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
         $error("spi_slave_shifter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // bit 2 = select, bit 1 = serial clock, bit 0 = data in
   logic [2:0] pins_s;
   logic       ss_s, sck_s, mosi_s;
   logic       smp_stb, shf_stb;
   spi_mode_t  cfg_mode, mode_q;

   assign cfg_mode = '{cpol: cfg_cpol, cpha: cfg_cpha};

   spi_slv_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ss_n_in, sck_in, mosi_in}),
      .sync_out (pins_s)
   );

   assign ss_s   = pins_s[2];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   spi_slv_edge edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s   (sck_s),
      .active  (~ss_s),
      .mode    (mode_q),
      .smp_stb (smp_stb),
      .shf_stb (shf_stb)
   );

   spi_slv_core #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_mode (cfg_mode),
      .ss_s     (ss_s),
      .mosi_s   (mosi_s),
      .smp_stb  (smp_stb),
      .shf_stb  (shf_stb),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte),
      .mode_q   (mode_q),
      .miso_bit (miso_out),
      .rx_byte  (rx_byte),
      .rx_done  (rx_done)
   );

   assign miso_oe = ~ss_s;

endmodule

// File: rtl/spi_slave_shifter_chk.sv
module spi_slave_shifter_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_done,
   input logic [DATA_W-1:0] rx_byte,
   input logic              miso_out,
   input logic              miso_oe,
   input logic              smp_stb,
   input logic              shf_stb,
   input logic              mode_cpol,
   input logic              mode_cpha
);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   assert_done_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(smp_stb));

   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> $stable(rx_byte));

   assert_done_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(miso_oe));

   assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(miso_oe) |-> ($stable(mode_cpol) && $stable(mode_cpha)));

   assert_miso_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(miso_oe) && !$past(smp_stb) && !$past(shf_stb)) |-> $stable(miso_out));

endmodule

bind spi_slave_shifter spi_slave_shifter_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_done   (rx_done),
   .rx_byte   (rx_byte),
   .miso_out  (miso_out),
   .miso_oe   (miso_oe),
   .smp_stb   (smp_stb),
   .shf_stb   (shf_stb),
   .mode_cpol (mode_q.cpol),
   .mode_cpha (mode_q.cpha)
);

// File: tb/spi_slave_shifter_tb_top.sv
module spi_slave_shifter_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  HALF       = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic       tx_load = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
   logic       miso_out, miso_oe, rx_done;
   logic [7:0] rx_byte;

   int checks = 0;
   int fails  = 0;
   bit reported = 1'b0;
   logic [7:0] sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_slave_shifter dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_cpol (cfg_cpol),
      .cfg_cpha (cfg_cpha),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte),
      .sck_in   (sck_in),
      .mosi_in  (mosi_in),
      .ss_n_in  (ss_n_in),
      .miso_out (miso_out),
      .miso_oe  (miso_oe),
      .rx_byte  (rx_byte),
      .rx_done  (rx_done)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_byte(input logic [7:0] b);
      tx_byte = b;
      tx_load = 1'b1;
      clks(1);
      tx_load = 1'b0;
   endtask

   // Monitor: every rx_done pops an expected byte (R8, R11, R12)
   always @(negedge clk) begin
      if (rst_n && rx_done) begin
         if (sb_q.size() == 0) begin
            check_eq("R11 unexpected rx_done", 32'(rx_done), 32'd0);
         end else begin
            check_eq("R8 rx_byte", 32'(rx_byte), 32'(sb_q.pop_front()));
         end
      end
   end

   // Driver: master-side transfer of nbits, checking miso bit by bit
   task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_miso,
                       input bit pol, input bit pha, input int nbits,
                       input bit sel_first, input bit release_end,
                       input bit poke_load, input bit poke_cfg, input string tag);
      if (nbits == 8) sb_q.push_back(mo);
      if (sel_first) begin
         sck_in = pol;
         cfg_cpol = pol;
         cfg_cpha = pha;
         clks(4);
         ss_n_in = 1'b0;
      end
      for (int i = 0; i < nbits; i++) begin
         if (pha == 1'b0) begin
            mosi_in = mo[7-i];
            if (poke_load && i == 3) begin
               load_byte(8'hFF);
               clks(HALF - 1);
            end else begin
               clks(HALF);
            end
            if (poke_cfg && i == 2) begin
               cfg_cpol = ~pol;
               cfg_cpha = ~pha;
            end
            check_eq({tag, " miso bit"}, 32'(miso_out), 32'(exp_miso[7-i]));
            if (i == 0) check_eq("R4 oe while selected", 32'(miso_oe), 32'd1);
            sck_in = ~pol;
            clks(HALF);
            sck_in = pol;
         end else begin
            sck_in = ~pol;
            mosi_in = mo[7-i];
            if (poke_load && i == 3) begin
               load_byte(8'hFF);
               clks(HALF - 1);
            end else begin
               clks(HALF);
            end
            if (poke_cfg && i == 2) begin
               cfg_cpol = ~pol;
               cfg_cpha = ~pha;
            end
            check_eq({tag, " miso bit"}, 32'(miso_out), 32'(exp_miso[7-i]));
            if (i == 0) check_eq("R4 oe while selected", 32'(miso_oe), 32'd1);
            sck_in = pol;
            clks(HALF);
         end
      end
      if (pha == 1'b0) clks(HALF);
      if (nbits == 8) check_eq("R9 miso echoes received MSB", 32'(miso_out), 32'(mo[7]));
      if (release_end) begin
         ss_n_in = 1'b1;
         clks(4);
         check_eq("R4 oe after release", 32'(miso_oe), 32'd0);
      end
   endtask

   initial begin
      clks(3);
      check_eq("R1 oe in reset", 32'(miso_oe), 32'd0);
      check_eq("R1 done in reset", 32'(rx_done), 32'd0);
      check_eq("R1 rx_byte in reset", 32'(rx_byte), 32'd0);
      rst_n = 1'b1;
      clks(4);
      check_eq("R1 oe after reset", 32'(miso_oe), 32'd0);
      check_eq("R1 rx_byte after reset", 32'(rx_byte), 32'd0);

      // R2: loads while deselected
      load_byte(8'h80);
      clks(2);
      check_eq("R2 load 0x80", 32'(miso_out), 32'd1);
      load_byte(8'h7F);
      clks(2);
      check_eq("R2 load 0x7F", 32'(miso_out), 32'd0);

      // R5/R7 mode 0, R6 mode 1, R7 modes 2 and 3
      load_byte(8'hA5);
      xfer(8'h3C, 8'hA5, 1'b0, 1'b0, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R5 mode0");
      load_byte(8'h5A);
      xfer(8'hC3, 8'h5A, 1'b0, 1'b1, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R6 mode1");
      load_byte(8'hF0);
      xfer(8'h0F, 8'hF0, 1'b1, 1'b0, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R7 mode2");
      load_byte(8'h81);
      xfer(8'h7E, 8'h81, 1'b1, 1'b1, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R7 mode3");

      // R3: load during transfer ignored
      load_byte(8'h4B);
      xfer(8'h2D, 8'h4B, 1'b0, 1'b1, 8, 1'b1, 1'b1, 1'b1, 1'b0, "R3 load ignored");

      // R11: abort after four bits, then a clean byte
      load_byte(8'hAA);
      xfer(8'hFF, 8'hAA, 1'b0, 1'b0, 4, 1'b1, 1'b1, 1'b0, 1'b0, "R11 partial");
      clks(10);
      check_eq("R11 rx_byte unchanged by abort", 32'(rx_byte), 32'h2D);
      load_byte(8'h12);
      xfer(8'h34, 8'h12, 1'b0, 1'b0, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R11 fresh byte");

      // R10: configuration changed mid-transfer
      load_byte(8'hC6);
      xfer(8'h95, 8'hC6, 1'b0, 1'b1, 8, 1'b1, 1'b1, 1'b0, 1'b1, "R10 cfg frozen");

      // R12: two bytes under one select, second echoes first (R9)
      load_byte(8'h96);
      xfer(8'h69, 8'h96, 1'b0, 1'b0, 8, 1'b1, 1'b0, 1'b0, 1'b0, "R12 byte1");
      xfer(8'hE1, 8'h69, 1'b0, 1'b0, 8, 1'b0, 1'b1, 1'b0, 1'b0, "R12 byte2");

      clks(10);
      check_eq("R8 all expected bytes seen", 32'(sb_q.size()), 32'd0);
      report();
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

endmodule